// File: doc/BRIEF.md
# Counting Binary-to-Decimal Converter

This block turns several binary words into decimal by counting. Each word arrives in ones' complement form. One extra count turns the stored value into its two's complement. A train of count pulses is then applied to each binary register and to that word's own BCD counter at the same time. A register stops taking pulses when it rolls over to zero. At that point its BCD counter holds the original value in decimal.

A sensitivity flag is captured when the event is strobed. It is shown as one more decimal digit, 0 or 1. After a fixed settling gap that follows the start pulse, the pulse source runs. A run-length limit shuts the source off if the words have not finished by then. The block is used as a short, fixed-latency post-processing step: it takes a strobe, counts, and reports completion.

Top module: `serial_bcd_converter`

## Requirements
- R1: Word i is presented on `comp_in[i*WIDTH +: WIDTH]` as the bitwise inverse of its value N. After the conversion finishes, that word's decimal output equals N, for every N from 0 to 2^WIDTH-1.
- R2: All words convert at the same time and independently. Each word stops counting when its own register reaches zero, so words with different values each end with their own value.
- R3: Each word's result is DIGITS BCD digits on `bcd_out[i*4*DIGITS +: 4*DIGITS]`, with the least significant digit in the lowest nibble. No digit ever exceeds 9.
- R4: An accepted start clears every decimal counter. The decimal outputs do not change while the block is idle and no start is applied.
- R5: An accepted start on clock edge 0 is followed by GAP_CYCLES idle edges. Count pulses then fall on edges GAP_CYCLES+1 onward, one per edge. `done` rises on edge GAP_CYCLES+M+1, where M is the largest word value.
- R6: The pulse source stops after RUN_LIMIT pulses. A word whose value exceeds RUN_LIMIT then reads RUN_LIMIT, and `done` rises on edge GAP_CYCLES+RUN_LIMIT+1.
- R7: `sens_in` is captured on the accepted start edge and shown on `sens_digit` as 4'd1 or 4'd0. It stays fixed until the next accepted start.
- R8: A word of value zero (all-ones input) receives no pulses and reads 000. When all words are zero, `done` rises on edge GAP_CYCLES+1.
- R9: `busy` is high from the accepted start until `done` rises. `done` then stays high until the next accepted start. A start pulse while `busy` is high is ignored, and the results in progress are unchanged.
- R10: After reset, `busy` and `done` are low, and all decimal outputs and `sens_digit` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Event strobe; accepted only when not busy |
| sens_in | input | 1 | Sensitivity flag, captured with the strobe |
| comp_in | input | NWORDS*WIDTH | Ones' complement of each word |
| bcd_out | output | NWORDS*4*DIGITS | Decimal result of each word |
| sens_digit | output | 4 | Sensitivity shown as decimal digit |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Results valid |

## Verification
Results are due a fixed number of edges after the accepted start: GAP_CYCLES plus the largest word value plus one, or plus RUN_LIMIT when the limit cuts the run short. For each run the bench computes this latency. It then counts falling edges after the start edge until `done` appears and compares the count with that latency. The decimal words and the sensitivity digit are read only once `done` is high, half a cycle away from the active edge. A second instance with a short run limit receives the same inputs, so the truncation timing is checked in the same sweep.

// File: rtl/serial_bcd_converter.sv
module serial_bcd_converter #(
  parameter int NWORDS     = 3,
  parameter int WIDTH      = 8,
  parameter int DIGITS     = 3,
  parameter int GAP_CYCLES = 4,
  parameter int RUN_LIMIT  = 300
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       sens_in,
  input  logic [NWORDS*WIDTH-1:0]    comp_in,
  output logic [NWORDS*4*DIGITS-1:0] bcd_out,
  output logic [3:0]                 sens_digit,
  output logic                       busy,
  output logic                       done
);
  localparam int BW = 4 * DIGITS;
  localparam int GW = $clog2(GAP_CYCLES + 1) + 1;
  localparam int RW = $clog2(RUN_LIMIT + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_RUN} state_t;

  state_t            state;
  logic [WIDTH-1:0]  bin_q [NWORDS];
  logic [BW-1:0]     dec_q [NWORDS];
  logic [NWORDS-1:0] active;
  logic [GW-1:0]     gap_cnt;
  logic [RW-1:0]     run_cnt;
  logic              sens_q, done_q;

  function automatic logic [BW-1:0] bcd_inc(input logic [BW-1:0] v);
    logic [BW-1:0] r;
    logic carry;
    r = v;
    carry = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (carry) begin
        if (r[d*4 +: 4] == 4'd9) r[d*4 +: 4] = 4'd0;
        else begin
          r[d*4 +: 4] = r[d*4 +: 4] + 4'd1;
          carry = 1'b0;
        end
      end
    end
    return r;
  endfunction

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    assign bcd_out[g*BW +: BW] = dec_q[g];
    assign active[g] = |bin_q[g];
  end

  assign sens_digit = {3'b000, sens_q};
  assign busy       = (state != S_IDLE);
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      gap_cnt <= '0;
      run_cnt <= '0;
      sens_q  <= 1'b0;
      done_q  <= 1'b0;
      for (int i = 0; i < NWORDS; i++) begin
        bin_q[i] <= '0;
        dec_q[i] <= '0;
      end
    end else begin
      case (state)
        S_IDLE: if (start) begin
          for (int i = 0; i < NWORDS; i++) begin
            bin_q[i] <= comp_in[i*WIDTH +: WIDTH] + WIDTH'(1);
            dec_q[i] <= '0;
          end
          sens_q  <= sens_in;
          done_q  <= 1'b0;
          gap_cnt <= '0;
          state   <= S_GAP;
        end
        S_GAP: begin
          if (gap_cnt == GW'(GAP_CYCLES - 1)) begin
            run_cnt <= '0;
            state   <= S_RUN;
          end else begin
            gap_cnt <= gap_cnt + GW'(1);
          end
        end
        S_RUN: begin
          if (!(|active) || run_cnt == RW'(RUN_LIMIT)) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            run_cnt <= run_cnt + RW'(1);
            for (int i = 0; i < NWORDS; i++) begin
              if (active[i]) begin
                bin_q[i] <= bin_q[i] + WIDTH'(1);
                dec_q[i] <= bcd_inc(dec_q[i]);
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_bcd_converter_chk.sv
module serial_bcd_converter_chk #(
  parameter int NWORDS = 3,
  parameter int DIGITS = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic [NWORDS*4*DIGITS-1:0] bcd_out,
  input logic [3:0]                 sens_digit,
  input logic                       busy,
  input logic                       done
);
  function automatic logic digits_ok(input logic [NWORDS*4*DIGITS-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < NWORDS*DIGITS; d++)
      if (v[d*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R3
  a_r3_digits_valid: assert property (@(posedge clk) disable iff (!rst_n)
    digits_ok(bcd_out));
  // R9
  a_r9_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R4
  a_r4_idle_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(bcd_out));
  // R7
  a_r7_sens_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sens_digit));
  // R7
  a_r7_sens_is_flag: assert property (@(posedge clk) disable iff (!rst_n)
    sens_digit <= 4'd1);
  // R9
  a_r9_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
endmodule

bind serial_bcd_converter serial_bcd_converter_chk #(.NWORDS(NWORDS), .DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bcd_out(bcd_out),
  .sens_digit(sens_digit), .busy(busy), .done(done)
);

// File: tb/serial_bcd_converter_tb.sv
module serial_bcd_converter_tb;
  localparam int NW = 3, W = 8, DG = 3, GAP = 4, LIM = 300, LIM2 = 20;
  localparam int BW = 4 * DG;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sens_in = 1'b0;
  logic [NW*W-1:0]  comp_in = '0;
  logic [NW*BW-1:0] bcd_a, bcd_b;
  logic [3:0]       sens_a, sens_b;
  logic             busy_a, busy_b, done_a, done_b;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  serial_bcd_converter #(.NWORDS(NW), .WIDTH(W), .DIGITS(DG), .GAP_CYCLES(GAP), .RUN_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sens_in(sens_in), .comp_in(comp_in),
    .bcd_out(bcd_a), .sens_digit(sens_a), .busy(busy_a), .done(done_a));

  serial_bcd_converter #(.NWORDS(NW), .WIDTH(W), .DIGITS(DG), .GAP_CYCLES(GAP), .RUN_LIMIT(LIM2)) u_lim (
    .clk(clk), .rst_n(rst_n), .start(start), .sens_in(sens_in), .comp_in(comp_in),
    .bcd_out(bcd_b), .sens_digit(sens_b), .busy(busy_b), .done(done_b));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int to_bin(input logic [BW-1:0] b);
    int r = 0;
    for (int d = DG - 1; d >= 0; d--) r = r * 10 + int'(b[d*4 +: 4]);
    return r;
  endfunction

  function automatic int maxv(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic convert(input int v0, input int v1, input int v2, input logic s, input logic poke);
    int vals[3];
    int ca, cb, mx, lim_mx;
    string req;
    vals[0] = v0; vals[1] = v1; vals[2] = v2;
    @(negedge clk);
    comp_in = {~W'(v2), ~W'(v1), ~W'(v0)};
    sens_in = s;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ca = 0; cb = 0;
    for (int c = 1; c < 700 && (ca == 0 || cb == 0); c++) begin
      if (poke && c == GAP + 3) begin
        comp_in = '0;
        sens_in = ~s;
        start   = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (ca == 0 && done_a) ca = c;
      if (cb == 0 && done_b) cb = c;
      if (ca == 0 || cb == 0) @(negedge clk);
    end
    start = 1'b0;
    mx = maxv(v0, maxv(v1, v2));
    lim_mx = (mx > LIM2) ? LIM2 : mx;
    // R5 / R8: done latency, counted in falling edges after the start edge
    req = (mx == 0) ? "R8" : "R5";
    chk(req, ca, GAP + mx + 2);
    chk("R6", cb, GAP + lim_mx + 2);
    for (int i = 0; i < NW; i++) begin
      req = (vals[i] == 0) ? "R8" : (poke ? "R9" : "R1");
      chk(req, to_bin(bcd_a[i*BW +: BW]), vals[i]);
      chk("R6", to_bin(bcd_b[i*BW +: BW]), (vals[i] > LIM2) ? LIM2 : vals[i]);
    end
    chk("R7", int'(sens_a), int'(s));
    chk("R9", int'(busy_a), 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk("R10", int'(busy_a), 0);
    chk("R10", int'(done_a), 0);
    chk("R10", int'(bcd_a), 0);
    chk("R10", int'(sens_a), 0);
    // R4: start absent, outputs hold
    repeat (5) @(negedge clk);
    chk("R4", int'(bcd_a), 0);
    // R1 example value 29, and R8 all-zero
    convert(29, 0, 0, 1'b1, 1'b0);
    convert(0, 0, 0, 1'b0, 1'b0);
    // R2: distinct independent words; R1 sweep over all values
    for (int v = 0; v < (1 << W); v++)
      convert(v, (1 << W) - 1 - v, (v * 37) % (1 << W), v[0], 1'b0);
    // R9: start during busy ignored
    convert(123, 7, 200, 1'b1, 1'b1);
    convert(5, 250, 0, 1'b0, 1'b1);
    // R4: results hold in idle
    repeat (10) @(negedge clk);
    chk("R4", to_bin(bcd_a[BW +: BW]), 250);
    chk("R9", int'(done_a), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule